// File: doc/BRIEF.md
# Link Stop/Start Cell Gate

This block sits between a cell link to a switch and the host side of a network adapter. It provides one flow-control signal for the whole link, carried in the 4-bit generic flow control (GFC) field at the top of every cell header. Arriving cells go into a short in-order FIFO. The FIFO holds them while the host bus is busy. When FIFO occupancy reaches a high-water mark, the block places a halt code in the GFC field of every cell it sends. When occupancy falls to a low-water mark, it places a go code there instead. The gap between the two marks gives hysteresis.

The transmit side works the other way round. It reads the GFC field of every arriving cell. A halt code from the switch stops the launch of new data cells on every connection until a go code arrives. The outbound link runs in fixed cell slots. A cell is launched in every slot, and an idle cell is sent whenever no data cell may or can go. Because of this, a change of local halt state reaches the switch within one slot. The switch stops feeding the link within one round trip, so buffering above the high-water mark only has to cover one round trip of cells.

Top module: `lsg_link_gate`

## Requirements
- R1: Non-idle arriving cells are delivered to the host whole and strictly in arrival order. `host_valid` is high exactly while at least one cell is held, and `host_cell` presents the oldest held cell.
- R2: An arriving cell whose bits below the GFC field are all zero is an idle cell. It is never stored, although its GFC code is still acted on.
- R3: A non-idle cell that arrives while all DEPTH entries are held and no pop happens in the same cycle is dropped, and `ovf_count` increases by one, saturating at its maximum. The cells already held are unaffected.
- R4: `local_halt` becomes 1 one cycle after occupancy is at or above HI.
- R5: `local_halt` becomes 0 one cycle after occupancy is at or below LO. Between the two marks it keeps its value.
- R6: Every cell launched on the link carries, in bits [W-1:W-4], the halt code 4'hA if `local_halt` was set at its slot start and the go code 4'h5 otherwise.
- R7: An arriving cell (idle or not) with GFC 4'hA halts the transmit side. From then on `tx_req_ready` stays low and every slot carries an idle cell (body bits zero).
- R8: An arriving GFC of 4'h5 resumes launching. Any other GFC code leaves the transmit state unchanged.
- R9: The link advances in slots of SLOT cycles. A launched cell stays unchanged on `link_cell` for its whole slot even if a halt arrives during it, and `tx_req_ready` pulses exactly once per slot while running.
- R10: While running, a held `tx_req_valid` has its body sent at each slot start. A slot with no request carries an idle cell, so `link_valid` stays high after the first slot.
- R11: After reset the FIFO is empty, `local_halt` is 0, `ovf_count` is 0, the transmit side is running and `link_valid` is 0 until the first slot start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A cell arrives from the link this cycle |
| rx_cell | input | W | Arriving cell, GFC in the top four bits |
| host_ready | input | 1 | Host takes the presented cell |
| host_valid | output | 1 | A held cell is presented |
| host_cell | output | W | Oldest held cell |
| tx_req_valid | input | 1 | Host has a data cell to send |
| tx_req_body | input | W-4 | Cell bits below the GFC field |
| tx_req_ready | output | 1 | Request accepted this cycle |
| link_valid | output | 1 | A cell is on the outbound link |
| link_cell | output | W | Outbound cell with GFC code |
| local_halt | output | 1 | Halt state being signalled to the switch |
| ovf_count | output | OVF_W | Dropped-cell count, saturating |

## Verification
The bench walks the FIFO up past the high-water mark and back down below the low-water mark. It samples `local_halt` at the point where an implementation without hysteresis, or with an off-by-one threshold, would release early or late. It overfills the FIFO and checks that the extra cells are counted and missing, while the held ones come out intact. An overwrite-on-full design would lose the oldest cells. It sends a halt code in the middle of a slot. A design that cut the cell short, or took one slot too long to react, shows up in the held `link_cell` and in the count of `tx_req_ready` pulses. Idle arriving cells and unknown GFC codes check that neither pollutes the FIFO nor wakes a halted transmitter.

// File: rtl/lsg_pkg.sv
package lsg_pkg;
  localparam int GFC_W = 4;
  localparam logic [GFC_W-1:0] GFC_HALT = 4'hA;
  localparam logic [GFC_W-1:0] GFC_GO   = 4'h5;

  // hysteresis rule for the local halt state
  function automatic logic next_halt(int fill, int hi, int lo, logic cur);
    if (fill >= hi) return 1'b1;
    if (fill <= lo) return 1'b0;
    return cur;
  endfunction

  // reaction of the transmit side to an arriving GFC code
  function automatic logic remote_next(logic [GFC_W-1:0] code, logic cur);
    if (code == GFC_HALT) return 1'b1;
    if (code == GFC_GO)   return 1'b0;
    return cur;
  endfunction

  function automatic int sat_inc(int v, int maxv);
    return (v >= maxv) ? v : v + 1;
  endfunction
endpackage

// File: rtl/lsg_cell_fifo.sv
module lsg_cell_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  parameter int OVF_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push_req,
  input  logic [W-1:0]                 din,
  input  logic                         pop_req,
  output logic                         nonempty,
  output logic [W-1:0]                 dout,
  output logic [$clog2(DEPTH+1)-1:0]   fill,
  output logic                         dropped,
  output logic [OVF_W-1:0]             ovf
);
  import lsg_pkg::*;
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OVF_MAX = (1 << OVF_W) - 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic          full, do_pop, do_push;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign nonempty = (fill != '0);
  assign full     = (fill == CNT_W'(DEPTH));
  assign do_pop   = pop_req && nonempty;
  assign do_push  = push_req && (!full || do_pop);
  assign dropped  = push_req && full && !do_pop;
  assign dout     = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      fill   <= '0;
      ovf    <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
      if (dropped) ovf <= OVF_W'(sat_inc(int'(ovf), OVF_MAX));
    end
  end
endmodule

// File: rtl/lsg_halt_hyst.sv
module lsg_halt_hyst #(
  parameter int DEPTH = 8,
  parameter int HI    = 6,
  parameter int LO    = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [$clog2(DEPTH+1)-1:0] fill,
  output logic                       halt
);
  import lsg_pkg::*;
  always_ff @(posedge clk) begin
    if (!rst_n) halt <= 1'b0;
    else        halt <= next_halt(int'(fill), HI, LO, halt);
  end
endmodule

// File: rtl/lsg_tx_gate.sv
module lsg_tx_gate #(
  parameter int W    = 32,
  parameter int SLOT = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_valid,
  input  logic [3:0]   rx_gfc,
  input  logic         local_halt,
  input  logic         req_valid,
  input  logic [W-5:0] req_body,
  output logic         req_ready,
  output logic         link_valid,
  output logic [W-1:0] link_cell,
  output logic         slot_start,
  output logic         remote_halt
);
  import lsg_pkg::*;
  localparam int SW = (SLOT > 1) ? $clog2(SLOT) : 1;

  logic [SW-1:0] cnt;
  logic          launch;

  assign slot_start = (cnt == '0);
  assign req_ready  = slot_start && !remote_halt;
  assign launch     = req_ready && req_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt         <= '0;
      remote_halt <= 1'b0;
      link_valid  <= 1'b0;
      link_cell   <= '0;
    end else begin
      cnt <= (cnt == SW'(SLOT-1)) ? '0 : cnt + 1'b1;
      if (rx_valid) remote_halt <= remote_next(rx_gfc, remote_halt);
      if (slot_start) begin
        link_valid <= 1'b1;
        link_cell  <= {(local_halt ? GFC_HALT : GFC_GO),
                       (launch ? req_body : {(W-4){1'b0}})};
      end
    end
  end
endmodule

// File: rtl/lsg_link_gate.sv
module lsg_link_gate #(
  parameter int W         = 32,
  parameter int DEPTH     = 8,
  parameter int HI        = 6,
  parameter int LO        = 2,
  parameter int SLOT      = 4,
  parameter int OVF_W     = 8,
  parameter int RTT_CELLS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic [W-1:0]     rx_cell,
  input  logic             host_ready,
  output logic             host_valid,
  output logic [W-1:0]     host_cell,
  input  logic             tx_req_valid,
  input  logic [W-5:0]     tx_req_body,
  output logic             tx_req_ready,
  output logic             link_valid,
  output logic [W-1:0]     link_cell,
  output logic             local_halt,
  output logic [OVF_W-1:0] ovf_count
);
  localparam int CNT_W = $clog2(DEPTH+1);

  // named internal events, observed by the bound checker
  logic             rx_idle_w;
  logic             drop_w;
  logic             slot_start_w;
  logic             remote_halt_w;
  logic [CNT_W-1:0] fill_w;

  assign rx_idle_w = (rx_cell[W-5:0] == '0);

  lsg_cell_fifo #(.W(W), .DEPTH(DEPTH), .OVF_W(OVF_W)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push_req(rx_valid && !rx_idle_w), .din(rx_cell),
    .pop_req(host_ready), .nonempty(host_valid), .dout(host_cell),
    .fill(fill_w), .dropped(drop_w), .ovf(ovf_count)
  );

  lsg_halt_hyst #(.DEPTH(DEPTH), .HI(HI), .LO(LO)) u_hyst (
    .clk(clk), .rst_n(rst_n), .fill(fill_w), .halt(local_halt)
  );

  lsg_tx_gate #(.W(W), .SLOT(SLOT)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_gfc(rx_cell[W-1:W-4]),
    .local_halt(local_halt),
    .req_valid(tx_req_valid), .req_body(tx_req_body), .req_ready(tx_req_ready),
    .link_valid(link_valid), .link_cell(link_cell),
    .slot_start(slot_start_w), .remote_halt(remote_halt_w)
  );
endmodule

// File: rtl/lsg_link_gate_chk.sv
module lsg_link_gate_chk #(
  parameter int W         = 32,
  parameter int DEPTH     = 8,
  parameter int HI        = 6,
  parameter int LO        = 2,
  parameter int OVF_W     = 8,
  parameter int RTT_CELLS = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       rx_valid,
  input logic                       rx_idle,
  input logic                       host_ready,
  input logic                       host_valid,
  input logic [$clog2(DEPTH+1)-1:0] fill,
  input logic                       drop,
  input logic [OVF_W-1:0]           ovf_count,
  input logic                       local_halt,
  input logic                       slot_start,
  input logic                       remote_halt,
  input logic                       tx_req_ready,
  input logic [W-1:0]               link_cell
);
  import lsg_pkg::*;
  localparam logic [OVF_W-1:0] OVF_MAX = '1;

  initial p_headroom_r4: assert (DEPTH - HI >= RTT_CELLS && LO < HI);

  p_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fill) <= DEPTH);
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_idle && !(host_ready && host_valid)) |=> (fill == $past(fill)));
  p_ovf_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && ovf_count != OVF_MAX) |=> (ovf_count == $past(ovf_count) + 1'b1));
  p_ovf_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !drop |=> $stable(ovf_count));
  p_halt_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(fill) >= HI) |=> local_halt);
  p_halt_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(fill) <= LO) |=> !local_halt);
  p_halt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(fill) > LO && int'(fill) < HI) |=> $stable(local_halt));
  p_gfc_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start |=> (link_cell[W-1:W-4] == ($past(local_halt) ? GFC_HALT : GFC_GO)));
  p_no_launch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    remote_halt |-> !tx_req_ready);
  p_cell_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_start |=> $stable(link_cell));
endmodule

bind lsg_link_gate lsg_link_gate_chk #(
  .W(W), .DEPTH(DEPTH), .HI(HI), .LO(LO), .OVF_W(OVF_W), .RTT_CELLS(RTT_CELLS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_idle(rx_idle_w),
  .host_ready(host_ready), .host_valid(host_valid), .fill(fill_w),
  .drop(drop_w), .ovf_count(ovf_count), .local_halt(local_halt),
  .slot_start(slot_start_w), .remote_halt(remote_halt_w),
  .tx_req_ready(tx_req_ready), .link_cell(link_cell)
);

// File: tb/sim_lsg_link_gate.sv
module sim_lsg_link_gate;
  localparam int W = 32, DEPTH = 8, SLOT = 4, OVF_W = 8;
  localparam logic [3:0] HALT = 4'hA, GO = 4'h5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 1'b0, host_ready = 1'b0, tx_req_valid = 1'b0;
  logic [W-1:0] rx_cell = '0;
  logic [W-5:0] tx_req_body = '0;
  logic host_valid, tx_req_ready, link_valid, local_halt;
  logic [W-1:0] host_cell, link_cell;
  logic [OVF_W-1:0] ovf_count;

  always #5 clk = ~clk;

  lsg_link_gate #(.W(W), .DEPTH(DEPTH), .HI(6), .LO(2), .SLOT(SLOT), .OVF_W(OVF_W)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_cell(rx_cell),
    .host_ready(host_ready), .host_valid(host_valid), .host_cell(host_cell),
    .tx_req_valid(tx_req_valid), .tx_req_body(tx_req_body), .tx_req_ready(tx_req_ready),
    .link_valid(link_valid), .link_cell(link_cell), .local_halt(local_halt),
    .ovf_count(ovf_count)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [W-1:0] q [0:63];
  int q_wr = 0, q_rd = 0, seq = 1;

  // {push, pop, expected local_halt after the step}
  localparam logic [2:0] TBL [18] = '{
    3'b100, 3'b100, 3'b100, 3'b100, 3'b100, 3'b101, 3'b101,
    3'b011, 3'b011, 3'b011, 3'b011, 3'b010,
    3'b100, 3'b100, 3'b010, 3'b010, 3'b010, 3'b010 };

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic send_rx(logic [W-1:0] c);
    @(negedge clk); rx_valid = 1'b1; rx_cell = c;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic push_data();
    logic [W-1:0] c;
    c = {4'h0, 28'(seq)};
    seq++;
    q[q_wr] = c; q_wr++;
    send_rx(c);
  endtask

  task automatic pop_check(string req);
    @(negedge clk);
    chk(host_valid == 1'b1, req, {31'd0, host_valid}, 32'd1);
    chk(host_cell == q[q_rd], req, host_cell, q[q_rd]);
    q_rd++;
    host_ready = 1'b1;
    @(negedge clk); host_ready = 1'b0;
  endtask

  task automatic count_ready(int cycles, output int k);
    k = 0;
    repeat (cycles) begin
      @(negedge clk);
      if (tx_req_ready) k++;
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog all-reqs actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11: reset state, before the first slot start
    chk(host_valid == 1'b0, "R11", {31'd0, host_valid}, 0);
    chk(local_halt == 1'b0, "R11", {31'd0, local_halt}, 0);
    chk(ovf_count == '0,   "R11", 32'(ovf_count), 0);
    chk(link_valid == 1'b0, "R11", {31'd0, link_valid}, 0);

    // R1 R4 R5: table walk over fill, drain and hysteresis
    for (int i = 0; i < 18; i++) begin
      if (TBL[i][1]) pop_check("R1");
      if (TBL[i][2]) push_data();
      @(negedge clk);
      chk(local_halt == TBL[i][0], (TBL[i][0] ? "R4" : "R5"),
          {31'd0, local_halt}, {31'd0, TBL[i][0]});
    end
    chk(host_valid == 1'b0, "R1", {31'd0, host_valid}, 0);

    // R2: idle arriving cell is not stored
    send_rx({GO, 28'h0});
    @(negedge clk);
    chk(host_valid == 1'b0, "R2", {31'd0, host_valid}, 0);

    // R3: overflow drops and counts, held cells intact
    for (int i = 0; i < DEPTH; i++) push_data();
    send_rx({4'h0, 28'hBAD0001});
    send_rx({4'h0, 28'hBAD0002});
    @(negedge clk);
    chk(ovf_count == 8'd2, "R3", 32'(ovf_count), 2);
    // R6: halt code goes out while full
    repeat (2 * SLOT) @(negedge clk);
    chk(link_cell[W-1:W-4] == HALT, "R6", 32'(link_cell[W-1:W-4]), 32'(HALT));
    chk(link_valid == 1'b1, "R10", {31'd0, link_valid}, 1);
    for (int i = 0; i < DEPTH; i++) pop_check("R3");
    chk(host_valid == 1'b0, "R3", {31'd0, host_valid}, 0);
    repeat (2 * SLOT) @(negedge clk);
    chk(link_cell[W-1:W-4] == GO, "R6", 32'(link_cell[W-1:W-4]), 32'(GO));

    // R10 R9: running, request sent once per slot
    tx_req_valid = 1'b1; tx_req_body = 28'h1234567;
    count_ready(3 * SLOT, k);
    chk(k == 3, "R9", 32'(k), 3);
    chk(link_cell == {GO, 28'h1234567}, "R10", link_cell, {GO, 28'h1234567});

    // R7 R9: halt arriving mid-slot, current cell completes
    do @(negedge clk); while (!tx_req_ready);
    @(negedge clk);
    rx_valid = 1'b1; rx_cell = {HALT, 28'h0};
    chk(link_cell[W-5:0] == 28'h1234567, "R9", link_cell, {GO, 28'h1234567});
    @(negedge clk); rx_valid = 1'b0;
    chk(link_cell[W-5:0] == 28'h1234567, "R9", link_cell, {GO, 28'h1234567});
    count_ready(2 * SLOT, k);
    chk(k == 0, "R7", 32'(k), 0);
    chk(link_cell == {GO, 28'h0}, "R7", link_cell, {GO, 28'h0});

    // R8: unknown code leaves the halt in place
    send_rx({4'h3, 28'h0});
    count_ready(2 * SLOT, k);
    chk(k == 0, "R8", 32'(k), 0);
    chk(host_valid == 1'b0, "R2", {31'd0, host_valid}, 0);

    // R8: go code resumes launches
    send_rx({GO, 28'h0});
    count_ready(3 * SLOT, k);
    chk(k == 3, "R8", 32'(k), 3);
    chk(link_cell == {GO, 28'h1234567}, "R8", link_cell, {GO, 28'h1234567});

    // R10: no request gives idle cells
    tx_req_valid = 1'b0;
    repeat (2 * SLOT) @(negedge clk);
    chk(link_cell == {GO, 28'h0}, "R10", link_cell, {GO, 28'h0});

    done = 1'b1;
    summary();
    $finish;
  end
endmodule